// File: doc/BRIEF.md
# File Byte-Read Control Sequencer

This block runs the read loop for a file that is already open on an external file-manager controller. It drives a command-frame sequencer, which adds any sync bytes and handles the serial link. When a start pulse arrives with a 16-bit byte count, the block issues a byte-read command that carries the count. It then waits for an interrupt status byte and branches on its value.

When the status reports that data is ready, the block asks for a data block. The reply opens with a length byte, and exactly that many data bytes follow. The block forwards each data byte on a valid-qualified output stream. It then issues a continue-read command and waits for the next status. A success status ends the read with a done pulse. Any other status ends it with an error pulse and keeps the code.

All three command opcodes and both recognised status codes are parameters, so they can be matched to the target device. The command arguments are handed to the sequencer as one 16-bit word together with an argument count.

Top module: `fbr_byte_reader`

## Requirements
- R1: After reset the block is idle. `busy`, `cmd_go`, `out_valid`, `done` and `error` are low, and `byte_count` is 0.
- R2: A `start` sampled while idle produces a `cmd_go` one cycle later. That command carries opcode `OP_READ` (default 0x3A), `cmd_nargs`=2 and `cmd_arg` equal to `req_len`. `cmd_arg[7:0]` is the byte the sequencer transmits first and `cmd_arg[15:8]` follows it. `busy` rises in the same cycle as that `cmd_go`.
- R3: `cmd_go` is high for exactly one cycle per command.
- R4: A status byte equal to `ST_RDY` (default 0x1D), received while waiting for status, produces a `cmd_go` one cycle later. That command carries opcode `OP_FETCH` (default 0x27) and `cmd_nargs`=0.
- R5: After a fetch command completes, the first received byte is the block length N. When N is nonzero, each of the next N received bytes appears on `out_byte` with `out_valid` one cycle after it is received. The cycle of the last data byte's output also carries a `cmd_go` with opcode `OP_CONT` (default 0x3B) and `cmd_nargs`=0.
- R6: A length byte of 0 produces no `out_valid`. The continue command issues one cycle after that length byte.
- R7: When a continue command completes (`cmd_done`), the block returns to waiting for status, and the next status byte is branched on again.
- R8: A status byte equal to `ST_OK` (default 0x14) ends the read. `done` pulses for one cycle one cycle later, and `busy` is low in that same cycle.
- R9: Any other status byte ends the read. `error` pulses for one cycle one cycle later, with `err_code` holding that byte, and `busy` goes low.
- R10: `byte_count` is cleared when a start is accepted. It increases by one in the cycle of each `out_valid`.
- R11: A `start` pulse while `busy` is high is ignored. No command is issued and `byte_count` keeps its value.
- R12: Bytes received while a command is still awaiting `cmd_done` are ignored. They produce no `out_valid`, no `done` and no `error`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a read (single-cycle) |
| req_len | input | 16 | Requested byte count for the read command |
| cmd_go | output | 1 | Command request strobe to the frame sequencer |
| cmd_op | output | 8 | Command opcode |
| cmd_nargs | output | 2 | Number of argument bytes (0 or 2) |
| cmd_arg | output | 16 | Argument word, low byte sent first |
| cmd_done | input | 1 | Sequencer finished sending the command |
| rx_valid | input | 1 | A byte was received from the device |
| rx_byte | input | 8 | Received byte |
| out_valid | output | 1 | Data byte valid |
| out_byte | output | 8 | Data byte |
| byte_count | output | CNT_W | Data bytes delivered since the last accepted start |
| busy | output | 1 | A read is in progress |
| done | output | 1 | Read ended with success status |
| error | output | 1 | Read ended with another status |
| err_code | output | 8 | Status byte that caused the last error |

## Verification
Every result is due exactly one clock after the input that causes it. This holds for the command strobe after a start or status byte, a data byte after it is received, and done or error after the final status. The bench drives each input for one full cycle from a falling edge and reads the result at the very next falling edge, so a late or early output shows up as a mismatch. A scoreboard holds the expected commands and data bytes in queues, and a monitor matches every strobe and data byte against them. An unexpected strobe or byte, such as one caused by an ignored start or by a byte arriving out of phase, is reported as a failure.

// File: rtl/fbr_pkg.sv
package fbr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_STAT,
    ST_FETCH,
    ST_LEN,
    ST_DATA,
    ST_CONT
  } fbr_state_e;

  // states that begin by handing a command to the frame sequencer
  function automatic logic is_cmd_state(fbr_state_e s);
    return (s == ST_REQ) || (s == ST_FETCH) || (s == ST_CONT);
  endfunction

  // remaining-bytes countdown step
  function automatic logic [7:0] blk_step(logic [7:0] r);
    return (r == 8'd0) ? 8'd0 : r - 8'd1;
  endfunction

  // delivered-byte counter step
  function automatic logic [31:0] tally_step(logic [31:0] c, logic clr, logic inc);
    if (clr) return 32'd0;
    return inc ? c + 32'd1 : c;
  endfunction

endpackage

// File: rtl/fbr_seq.sv
module fbr_seq
  import fbr_pkg::*;
#(
  parameter int             BYTE_W = 8,
  parameter logic [BYTE_W-1:0] ST_OK  = 8'h14,
  parameter logic [BYTE_W-1:0] ST_RDY = 8'h1D
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              cmd_done,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              blk_last,
  output fbr_state_e        state,
  output fbr_state_e        nxt,
  output logic              evt_accept,
  output logic              evt_issue,
  output logic              evt_ok,
  output logic              evt_bad,
  output logic              evt_len_nz,
  output logic              evt_data
);

  always_comb begin
    nxt        = state;
    evt_accept = 1'b0;
    evt_ok     = 1'b0;
    evt_bad    = 1'b0;
    evt_len_nz = 1'b0;
    evt_data   = 1'b0;
    case (state)
      ST_IDLE: if (start) begin
        nxt        = ST_REQ;
        evt_accept = 1'b1;
      end
      ST_REQ:   if (cmd_done) nxt = ST_STAT;
      ST_FETCH: if (cmd_done) nxt = ST_LEN;
      ST_CONT:  if (cmd_done) nxt = ST_STAT;
      ST_STAT: if (rx_valid) begin
        if (rx_byte == ST_RDY) nxt = ST_FETCH;
        else if (rx_byte == ST_OK) begin
          nxt    = ST_IDLE;
          evt_ok = 1'b1;
        end else begin
          nxt     = ST_IDLE;
          evt_bad = 1'b1;
        end
      end
      ST_LEN: if (rx_valid) begin
        if (rx_byte == '0) nxt = ST_CONT;
        else begin
          nxt        = ST_DATA;
          evt_len_nz = 1'b1;
        end
      end
      ST_DATA: if (rx_valid) begin
        evt_data = 1'b1;
        if (blk_last) nxt = ST_CONT;
      end
      default: nxt = ST_IDLE;
    endcase
    evt_issue = is_cmd_state(nxt) && (nxt != state);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end

  assert_single_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(evt_ok && evt_bad));

  // R12: while a command is outstanding, received bytes move nothing
  assert_cmd_wait_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (is_cmd_state(state) && !cmd_done) |=> $stable(state));

endmodule

// File: rtl/fbr_blk_cnt.sv
module fbr_blk_cnt
  import fbr_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [BYTE_W-1:0] len,
  input  logic              step,
  output logic              last
);

  logic [7:0] remaining;

  always_ff @(posedge clk) begin
    if (!rst_n)    remaining <= '0;
    else if (load) remaining <= 8'(len);
    else if (step) remaining <= blk_step(remaining);
  end

  assign last = (remaining == 8'd1);

  assert_no_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (remaining != 8'd0));

endmodule

// File: rtl/fbr_tally.sv
module fbr_tally
  import fbr_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);

  always_ff @(posedge clk) begin
    if (!rst_n) count <= '0;
    else        count <= CNT_W'(tally_step(32'(count), clr, inc));
  end

  assert_count_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (count == '0));

  assert_count_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !clr) |=> (count == $past(count) + 1'b1));

endmodule

// File: rtl/fbr_byte_reader.sv
module fbr_byte_reader
  import fbr_pkg::*;
#(
  parameter int         CNT_W    = 24,
  parameter int         REQ_W    = 16,
  parameter logic [7:0] OP_READ  = 8'h3A,
  parameter logic [7:0] OP_FETCH = 8'h27,
  parameter logic [7:0] OP_CONT  = 8'h3B,
  parameter logic [7:0] ST_OK    = 8'h14,
  parameter logic [7:0] ST_RDY   = 8'h1D
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [REQ_W-1:0] req_len,
  output logic             cmd_go,
  output logic [7:0]       cmd_op,
  output logic [1:0]       cmd_nargs,
  output logic [REQ_W-1:0] cmd_arg,
  input  logic             cmd_done,
  input  logic             rx_valid,
  input  logic [7:0]       rx_byte,
  output logic             out_valid,
  output logic [7:0]       out_byte,
  output logic [CNT_W-1:0] byte_count,
  output logic             busy,
  output logic             done,
  output logic             error,
  output logic [7:0]       err_code
);

  localparam int BYTE_W = 8;

  fbr_state_e state, nxt;
  logic evt_accept, evt_issue, evt_ok, evt_bad, evt_len_nz, evt_data;
  logic blk_last;
  logic [7:0] op_sel;

  fbr_seq #(.BYTE_W(BYTE_W), .ST_OK(ST_OK), .ST_RDY(ST_RDY)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd_done(cmd_done),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .blk_last(blk_last),
    .state(state), .nxt(nxt), .evt_accept(evt_accept), .evt_issue(evt_issue),
    .evt_ok(evt_ok), .evt_bad(evt_bad), .evt_len_nz(evt_len_nz), .evt_data(evt_data)
  );

  fbr_blk_cnt #(.BYTE_W(BYTE_W)) u_blk (
    .clk(clk), .rst_n(rst_n), .load(evt_len_nz), .len(rx_byte),
    .step(evt_data), .last(blk_last)
  );

  fbr_tally #(.CNT_W(CNT_W)) u_tally (
    .clk(clk), .rst_n(rst_n), .clr(evt_accept), .inc(evt_data), .count(byte_count)
  );

  always_comb begin
    case (nxt)
      ST_REQ:   op_sel = OP_READ;
      ST_FETCH: op_sel = OP_FETCH;
      default:  op_sel = OP_CONT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_go    <= 1'b0;
      cmd_op    <= '0;
      cmd_nargs <= '0;
      cmd_arg   <= '0;
      out_valid <= 1'b0;
      out_byte  <= '0;
      done      <= 1'b0;
      error     <= 1'b0;
      err_code  <= '0;
    end else begin
      cmd_go    <= evt_issue;
      out_valid <= evt_data;
      done      <= evt_ok;
      error     <= evt_bad;
      if (evt_issue) begin
        cmd_op    <= op_sel;
        cmd_nargs <= (nxt == ST_REQ) ? 2'd2 : 2'd0;
        cmd_arg   <= (nxt == ST_REQ) ? req_len : '0;
      end
      if (evt_data) out_byte <= rx_byte;
      if (evt_bad)  err_code <= rx_byte;
    end
  end

  assign busy = (state != ST_IDLE);

  assert_go_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_go |=> !cmd_go);

  assert_start_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (cmd_go && cmd_op == OP_READ && cmd_nargs == 2'd2));

  assert_rdy_fetch_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_STAT && rx_valid && rx_byte == ST_RDY) |=> (cmd_go && cmd_op == OP_FETCH));

  assert_out_src_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(rx_valid));

  assert_end_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done || error) |-> (!busy && !(done && error)));

  assert_busy_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !cmd_done && !rx_valid) |=> busy);

endmodule

// File: tb/test_fbr_byte_reader.sv
module test_fbr_byte_reader;

  localparam logic [7:0] OP_READ = 8'h3A, OP_FETCH = 8'h27, OP_CONT = 8'h3B;
  localparam logic [7:0] ST_OK = 8'h14, ST_RDY = 8'h1D;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, cmd_done = 1'b0, rx_valid = 1'b0;
  logic [15:0] req_len = '0;
  logic [7:0]  rx_byte = '0;
  logic cmd_go, out_valid, busy, done, error;
  logic [7:0] cmd_op, out_byte, err_code;
  logic [1:0] cmd_nargs;
  logic [15:0] cmd_arg;
  logic [23:0] byte_count;

  int checks = 0, errors = 0;
  logic [7:0]  exp_data[$];
  logic [25:0] exp_cmd[$];

  always #2 clk = ~clk;

  fbr_byte_reader i_fbr_byte_reader (
    .clk(clk), .rst_n(rst_n), .start(start), .req_len(req_len),
    .cmd_go(cmd_go), .cmd_op(cmd_op), .cmd_nargs(cmd_nargs), .cmd_arg(cmd_arg),
    .cmd_done(cmd_done), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .out_valid(out_valid), .out_byte(out_byte), .byte_count(byte_count),
    .busy(busy), .done(done), .error(error), .err_code(err_code)
  );

  task automatic check(input logic ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) if (rst_n) begin
    if (cmd_go) begin
      if (exp_cmd.size() == 0) check(1'b0, "R11 unexpected command", cmd_op, 0);
      else begin
        logic [25:0] e;
        e = exp_cmd.pop_front();
        check({cmd_op, cmd_nargs, cmd_arg} == e, "R2 command contents",
              {cmd_op, cmd_nargs, cmd_arg}, e);
      end
    end
    if (out_valid) begin
      if (exp_data.size() == 0) check(1'b0, "R12 unexpected data byte", out_byte, 0);
      else begin
        logic [7:0] d;
        d = exp_data.pop_front();
        check(out_byte == d, "R5 data byte", out_byte, d);
      end
    end
  end

  task automatic push_cmd(input logic [7:0] op, input logic [1:0] n, input logic [15:0] a);
    exp_cmd.push_back({op, n, a});
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk); rx_valid = 1'b1; rx_byte = b;
    @(negedge clk); rx_valid = 1'b0;
  endtask

  task automatic finish_cmd();
    @(negedge clk); cmd_done = 1'b1;
    @(negedge clk); cmd_done = 1'b0;
  endtask

  task automatic begin_read(input logic [15:0] len);
    push_cmd(OP_READ, 2'd2, len);
    @(negedge clk); start = 1'b1; req_len = len;
    @(negedge clk); start = 1'b0;
    check(cmd_go === 1'b1, "R2 read command one cycle after start", cmd_go, 1);
    check(busy === 1'b1, "R2 busy with command", busy, 1);
    check(byte_count == 0, "R10 count cleared on start", byte_count, 0);
  endtask

  task automatic fetch_block(input int n, input int seed);
    push_cmd(OP_FETCH, 2'd0, 16'h0);
    send_byte(ST_RDY);
    check(cmd_go === 1'b1 && cmd_op == OP_FETCH, "R4 fetch after ready status", cmd_op, OP_FETCH);
    finish_cmd();
    if (n == 0) begin
      push_cmd(OP_CONT, 2'd0, 16'h0);
      send_byte(8'h00);
      check(cmd_go === 1'b1 && out_valid === 1'b0, "R6 zero length goes to continue", cmd_op, OP_CONT);
    end else begin
      send_byte(8'(n));
      for (int i = 0; i < n; i++) begin
        exp_data.push_back(8'(i * 7 + seed));
        if (i == n - 1) push_cmd(OP_CONT, 2'd0, 16'h0);
        send_byte(8'(i * 7 + seed));
        check(out_valid === 1'b1, "R5 byte out one cycle after receipt", out_valid, 1);
      end
      check(cmd_go === 1'b1 && cmd_op == OP_CONT, "R5 continue after last byte", cmd_op, OP_CONT);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !cmd_go && !out_valid && !done && !error && byte_count == 0,
          "R1 reset state", {busy, cmd_go, out_valid, done, error}, 0);
    rst_n = 1'b1;

    // read with one 3-byte block, then an empty block, then success
    begin_read(16'h0105);
    @(negedge clk);
    check(cmd_go === 1'b0, "R3 command strobe lasts one cycle", cmd_go, 0);
    finish_cmd();
    fetch_block(3, 16);
    check(byte_count == 3, "R10 count after block", byte_count, 3);
    start = 1'b1; req_len = 16'hBEEF;
    @(negedge clk); start = 1'b0;
    check(cmd_go === 1'b0 && busy && byte_count == 3, "R11 start while busy ignored", byte_count, 3);
    finish_cmd();
    fetch_block(0, 0);
    check(byte_count == 3, "R6 zero length adds nothing", byte_count, 3);
    finish_cmd();
    send_byte(ST_OK);
    check(done === 1'b1 && !busy && !error, "R8 done after success status", done, 1);
    check(byte_count == 3, "R10 final count", byte_count, 3);
    @(negedge clk);
    check(done === 1'b0, "R8 done is a pulse", done, 0);

    // error path with a stray byte during a pending command
    begin_read(16'h0010);
    send_byte(ST_OK);
    check(!done && !out_valid && busy, "R12 byte ignored while command pending", done, 0);
    finish_cmd();
    send_byte(8'h42);
    check(error === 1'b1 && err_code == 8'h42 && !busy, "R9 error with latched code", err_code, 8'h42);
    @(negedge clk);
    check(error === 1'b0 && err_code == 8'h42, "R9 error pulse, code held", err_code, 8'h42);

    // full-length block, a second loop through status (R7)
    begin_read(16'h0200);
    finish_cmd();
    fetch_block(255, 3);
    finish_cmd();
    fetch_block(2, 9);
    finish_cmd();
    send_byte(ST_OK);
    check(done === 1'b1 && byte_count == 257, "R7 loop returns to status; total count", byte_count, 257);

    repeat (2) @(negedge clk);
    check(exp_cmd.size() == 0 && exp_data.size() == 0, "R5 scoreboard drained",
          exp_cmd.size() + exp_data.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule